// File: doc/BRIEF.md
# Serial Three-Wire Register Loader

This block is the write port of a synthesizer's configuration register file. Software or a controller on another device sends 21-bit words over three slow wires: a bit clock, a data line and a load strobe. The block samples all three into the system clock domain, shifts one data bit in on each rising bit-clock edge (most significant bit first), and, when the load strobe rises, copies the 19 payload bits of the word into one of four holding registers. The two least significant bits of the word, the last two sent, pick the destination.

All four holding registers are visible as one flat parallel output, destination `k` in bits `[k*19 +: 19]`. A one-cycle load pulse with the 2-bit destination number tells downstream logic which register was written. A readback tap shows the oldest bit held in the shift register; it refreshes only on falling bit-clock edges, so a bus master can read it back while it shifts.

Top module: `cfg_serial_loader`

## Requirements
- R1: While reset is asserted, and after its release until the first load, all four holding registers read zero, the load pulse is low and the readback tap is low.
- R2: Data is taken on rising bit-clock edges, first bit sent ending in frame bit 20, so the payload written is frame bits [20:2]. The first bit sent is the payload MSB.
- R3: Frame bits [1:0] select the destination: value k writes holding register k (k = 0..3), and the load pulse carries that value on `ld_addr_o`.
- R4: A load changes only the addressed holding register. The other three keep their contents.
- R5: Each rise of the load strobe gives exactly one load and one single-cycle `ld_stb_o` pulse, however long the strobe stays high. Nothing is loaded without a strobe rise.
- R6: Bit-clock edges that arrive while the load strobe is high do not shift. A second strobe after such edges writes the same frame again.
- R7: `rdbk_o` takes the value of frame bit 20 only after a falling bit-clock edge. It does not change on a rising edge.
- R8: Holding registers keep their contents while bits are shifted in with the strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial bit clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, asynchronous |
| ser_le_i | input | 1 | Load strobe, asynchronous |
| dst_q_o | output | 76 | Four 19-bit holding registers, register k at [k*19 +: 19] |
| ld_stb_o | output | 1 | One-cycle pulse when a holding register is written |
| ld_addr_o | output | 2 | Destination number of the latest load |
| rdbk_o | output | 1 | Readback tap: oldest shift-register bit, refreshed on falling bit-clock |

## Verification
The bench walks a table of frames across all four destinations. Payloads are chosen so that a reversed bit order or a misplaced address field writes a wrong value or hits the wrong register. It toggles the bit clock while the strobe is held high: a design that keeps shifting then would store a corrupted word on the next load, and one that loads on the strobe level instead of its rise would give more than one pulse. The readback tap is checked just after a rising edge and again after the falling edge, which catches a tap taken from the wrong edge or the wrong end of the register. A reset after several loads must clear every register.

// File: rtl/cfg_ldr_pkg.sv
package cfg_ldr_pkg;

  // Result of comparing a synchronized signal with its value one cycle ago
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10
  } edge_e;

  localparam int unsigned FRAME_W_DEF = 21;
  localparam int unsigned ADDR_W_DEF  = 2;
  localparam int unsigned SYNC_N_DEF  = 2;

endpackage

// File: rtl/cfg_ldr_sync.sv
module cfg_ldr_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  localparam int unsigned CHAIN_W = W * STAGES;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_d;

  // Each stage takes the one below it; stage 0 takes the raw inputs
  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = d_i;
    end else begin : g_multi
      always_comb chain_d = {chain_q[CHAIN_W-W-1:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q_o = chain_q[CHAIN_W-1 -: W];

endmodule

// File: rtl/cfg_ldr_edge.sv
module cfg_ldr_edge
  import cfg_ldr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sig_i,
  output edge_e kind_o
);

  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = sig_i;
    kind_o = EDGE_NONE;
    if (sig_i && !prev_q) begin
      kind_o = EDGE_RISE;
    end else if (!sig_i && prev_q) begin
      kind_o = EDGE_FALL;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
    end
  end

endmodule

// File: rtl/cfg_ldr_shift.sv
module cfg_ldr_shift #(
  parameter int unsigned FRAME_W = 21
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               shift_en_i,
  input  logic               tap_en_i,
  input  logic               bit_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               tail_o
);

  logic [FRAME_W-1:0] sreg_q;
  logic [FRAME_W-1:0] sreg_d;
  logic               tail_q;
  logic               tail_d;

  always_comb begin
    sreg_d = sreg_q;
    tail_d = tail_q;
    if (shift_en_i) begin
      sreg_d = {sreg_q[FRAME_W-2:0], bit_i};
    end
    if (tap_en_i) begin
      tail_d = sreg_q[FRAME_W-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      tail_q <= 1'b0;
    end else begin
      sreg_q <= sreg_d;
      tail_q <= tail_d;
    end
  end

  assign frame_o = sreg_q;
  assign tail_o  = tail_q;

endmodule

// File: rtl/cfg_ldr_bank.sv
module cfg_ldr_bank #(
  parameter int unsigned FRAME_W = 21,
  parameter int unsigned ADDR_W  = 2
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   load_en_i,
  input  logic [FRAME_W-1:0]                     frame_i,
  output logic [(1<<ADDR_W)*(FRAME_W-ADDR_W)-1:0] dst_o,
  output logic                                   stb_o,
  output logic [ADDR_W-1:0]                      addr_o
);

  localparam int unsigned PAY_W   = FRAME_W - ADDR_W;
  localparam int unsigned NUM_DST = 1 << ADDR_W;

  logic [ADDR_W-1:0] sel;
  logic [PAY_W-1:0]  pay;
  logic              stb_q;
  logic              stb_d;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_d;

  assign sel = frame_i[ADDR_W-1:0];
  assign pay = frame_i[FRAME_W-1:ADDR_W];

  generate
    for (genvar k = 0; k < NUM_DST; k++) begin : g_slot
      localparam logic [ADDR_W-1:0] SLOT_ID = ADDR_W'(k);
      logic             hit;
      logic [PAY_W-1:0] slot_q;
      logic [PAY_W-1:0] slot_d;

      always_comb begin
        hit    = load_en_i && (sel == SLOT_ID);
        slot_d = hit ? pay : slot_q;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          slot_q <= '0;
        end else begin
          slot_q <= slot_d;
        end
      end

      assign dst_o[k*PAY_W +: PAY_W] = slot_q;
    end
  endgenerate

  always_comb begin
    stb_d  = load_en_i;
    addr_d = load_en_i ? sel : addr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      stb_q  <= stb_d;
      addr_q <= addr_d;
    end
  end

  assign stb_o  = stb_q;
  assign addr_o = addr_q;

endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfg_ldr_pkg::*;
#(
  parameter int unsigned FRAME_W = FRAME_W_DEF,
  parameter int unsigned ADDR_W  = ADDR_W_DEF,
  parameter int unsigned SYNC_N  = SYNC_N_DEF
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   ser_clk_i,
  input  logic                                   ser_dat_i,
  input  logic                                   ser_le_i,
  output logic [(1<<ADDR_W)*(FRAME_W-ADDR_W)-1:0] dst_q_o,
  output logic                                   ld_stb_o,
  output logic [ADDR_W-1:0]                      ld_addr_o,
  output logic                                   rdbk_o
);

  localparam int unsigned IN_W   = 3;
  localparam int unsigned IX_CLK = 0;
  localparam int unsigned IX_DAT = 1;
  localparam int unsigned IX_LE  = 2;

  logic [IN_W-1:0]    raw;
  logic [IN_W-1:0]    syn;
  edge_e              clk_kind;
  edge_e              le_kind;
  logic               shift_en;
  logic               tap_en;
  logic               load_en;
  logic [FRAME_W-1:0] frame;

  assign raw = {ser_le_i, ser_dat_i, ser_clk_i};

  cfg_ldr_sync #(.W(IN_W), .STAGES(SYNC_N)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw),
    .q_o    (syn)
  );

  cfg_ldr_edge u_clk_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (syn[IX_CLK]),
    .kind_o (clk_kind)
  );

  cfg_ldr_edge u_le_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (syn[IX_LE]),
    .kind_o (le_kind)
  );

  // Shifting is frozen while the load strobe is high
  always_comb begin
    shift_en = (clk_kind == EDGE_RISE) && !syn[IX_LE];
    tap_en   = (clk_kind == EDGE_FALL);
    load_en  = (le_kind == EDGE_RISE);
  end

  cfg_ldr_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_en_i (shift_en),
    .tap_en_i   (tap_en),
    .bit_i      (syn[IX_DAT]),
    .frame_o    (frame),
    .tail_o     (rdbk_o)
  );

  cfg_ldr_bank #(.FRAME_W(FRAME_W), .ADDR_W(ADDR_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_en_i (load_en),
    .frame_i   (frame),
    .dst_o     (dst_q_o),
    .stb_o     (ld_stb_o),
    .addr_o    (ld_addr_o)
  );

endmodule

// File: rtl/cfg_serial_loader_chk.sv
module cfg_serial_loader_chk #(
  parameter int unsigned FRAME_W = 21,
  parameter int unsigned ADDR_W  = 2,
  parameter int unsigned SYNC_N  = 2
) (
  input logic                                   clk_i,
  input logic                                   rst_ni,
  input logic                                   ser_le_i,
  input logic [(1<<ADDR_W)*(FRAME_W-ADDR_W)-1:0] dst_q_o,
  input logic                                   ld_stb_o,
  input logic [ADDR_W-1:0]                      ld_addr_o
);

  localparam int unsigned PAY_W   = FRAME_W - ADDR_W;
  localparam int unsigned NUM_DST = 1 << ADDR_W;

  // Delay line of the raw strobe, long enough to cover the sync latency
  logic [SYNC_N:0] le_hist;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      le_hist <= '0;
    end else begin
      le_hist <= {le_hist[SYNC_N-1:0], ser_le_i};
    end
  end

  // R5: a load pulse never lasts two cycles
  p_stb_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_stb_o |=> !ld_stb_o);

  // R5: a load pulse is always preceded by a high strobe at the pins
  p_stb_has_le_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_stb_o |-> le_hist[SYNC_N]);

  // R8: the register file only moves together with a load pulse
  p_hold_without_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dst_q_o) |-> ld_stb_o);

  // R4: a load leaves every other destination alone
  generate
    for (genvar k = 0; k < NUM_DST; k++) begin : g_slot_chk
      p_other_slot_kept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ld_stb_o && (ld_addr_o != ADDR_W'(k))) |-> $stable(dst_q_o[k*PAY_W +: PAY_W]));
    end
  endgenerate

endmodule

bind cfg_serial_loader cfg_serial_loader_chk #(
  .FRAME_W (FRAME_W),
  .ADDR_W  (ADDR_W),
  .SYNC_N  (SYNC_N)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ser_le_i  (ser_le_i),
  .dst_q_o   (dst_q_o),
  .ld_stb_o  (ld_stb_o),
  .ld_addr_o (ld_addr_o)
);

// File: tb/cfg_serial_loader_tb_top.sv
module cfg_serial_loader_tb_top;

  localparam int FW    = 21;
  localparam int AW    = 2;
  localparam int PW    = FW - AW;
  localparam int ND    = 1 << AW;
  localparam int NVEC  = 6;

  // Each entry: {payload, destination}
  localparam logic [FW-1:0] VEC [NVEC] = '{
    {19'h7FFFF, 2'd0},
    {19'h12345, 2'd1},
    {19'h40001, 2'd2},
    {19'h2AAAA, 2'd3},
    {19'h00000, 2'd0},
    {19'h55555, 2'd2}
  };

  logic            clk;
  logic            rst_n;
  logic            ser_clk;
  logic            ser_dat;
  logic            ser_le;
  logic [ND*PW-1:0] dst_q;
  logic            ld_stb;
  logic [AW-1:0]   ld_addr;
  logic            rdbk;

  int total = 0;
  int bad   = 0;
  int stb_cnt = 0;
  logic [AW-1:0] stb_addr;
  logic [PW-1:0] model [ND];
  bit done = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  cfg_serial_loader dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .ser_clk_i (ser_clk),
    .ser_dat_i (ser_dat),
    .ser_le_i  (ser_le),
    .dst_q_o   (dst_q),
    .ld_stb_o  (ld_stb),
    .ld_addr_o (ld_addr),
    .rdbk_o    (rdbk)
  );

  always @(posedge clk) begin
    if (rst_n && ld_stb) begin
      stb_cnt  <= stb_cnt + 1;
      stb_addr <= ld_addr;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    ser_dat = b;
    wait_n(3);
    ser_clk = 1'b1;
    wait_n(4);
    ser_clk = 1'b0;
    wait_n(4);
  endtask

  task automatic send_frame(input logic [FW-1:0] f);
    for (int i = FW - 1; i >= 0; i--) send_bit(f[i]);
  endtask

  task automatic pulse_le(input int hold);
    ser_le = 1'b1;
    wait_n(hold);
    ser_le = 1'b0;
    wait_n(6);
  endtask

  task automatic check_all(input string req);
    for (int k = 0; k < ND; k++) begin
      check(dst_q[k*PW +: PW] == model[k], req, 32'(dst_q[k*PW +: PW]), 32'(model[k]));
    end
  endtask

  initial begin
    int pre;
    logic [FW-1:0] fa;
    logic [FW-1:0] fb;
    rst_n   = 1'b0;
    ser_clk = 1'b0;
    ser_dat = 1'b0;
    ser_le  = 1'b0;
    for (int k = 0; k < ND; k++) model[k] = '0;
    wait_n(4);
    // R1: reset state
    check(dst_q == '0, "R1 regs", 32'(dst_q[31:0]), 0);
    check(!ld_stb && !rdbk, "R1 stb/rdbk", {30'd0, ld_stb, rdbk}, 0);
    rst_n = 1'b1;
    wait_n(4);
    check(dst_q == '0 && stb_cnt == 0, "R1 after release", 32'(stb_cnt), 0);

    // Table walk: R2, R3, R4, R5, R8
    for (int v = 0; v < NVEC; v++) begin
      send_frame(VEC[v]);
      check_all("R8 hold while shifting");
      pre = stb_cnt;
      pulse_le(6);
      check(stb_cnt == pre + 1, "R5 one pulse", 32'(stb_cnt - pre), 1);
      check(stb_addr == VEC[v][AW-1:0], "R3 address", 32'(stb_addr), 32'(VEC[v][AW-1:0]));
      model[VEC[v][AW-1:0]] = VEC[v][FW-1:AW];
      check_all("R2/R4 contents");
    end

    // R6 and R5: bit-clock edges while strobe high, long strobe
    fa = {19'h3C3C3, 2'd1};
    send_frame(fa);
    pre = stb_cnt;
    ser_le = 1'b1;
    wait_n(6);
    for (int j = 0; j < 3; j++) send_bit(1'b1);
    wait_n(30);
    ser_le = 1'b0;
    wait_n(6);
    check(stb_cnt == pre + 1, "R5 long strobe", 32'(stb_cnt - pre), 1);
    model[1] = fa[FW-1:AW];
    check_all("R6 first load");
    pulse_le(6);
    check(stb_cnt == pre + 2, "R6 second pulse", 32'(stb_cnt - pre), 2);
    check_all("R6 no shift under strobe");

    // R7: readback tap refreshes on falling edges only
    fa = {19'h5B2D1, 2'd2};
    fb = {19'h00000, 2'd0};
    send_frame(fa);
    check(rdbk == fa[FW-1], "R7 tap after frame", 32'(rdbk), 32'(fa[FW-1]));
    for (int j = 0; j < 6; j++) begin
      ser_dat = fb[FW-1-j];
      wait_n(3);
      ser_clk = 1'b1;
      wait_n(4);
      check(rdbk == fa[FW-1-j], "R7 steady after rise", 32'(rdbk), 32'(fa[FW-1-j]));
      ser_clk = 1'b0;
      wait_n(4);
      check(rdbk == fa[FW-2-j], "R7 after fall", 32'(rdbk), 32'(fa[FW-2-j]));
    end
    check_all("R8 after readback shifts");

    // R1: reset after loads clears everything
    rst_n = 1'b0;
    wait_n(2);
    check(dst_q == '0 && !rdbk && !ld_stb, "R1 mid-run reset", 32'(dst_q[31:0]), 0);
    rst_n = 1'b1;
    wait_n(2);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule